// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits inside one programmable-logic block and decides which macrocell each group of product terms feeds. Forty-eight product-term results arrive as twelve clusters of four terms. A held configuration word gives every cluster an enable bit and a 2-bit offset that picks one macrocell from a small sliding window of neighbours. The block ORs together every term of the clusters steered to each macrocell and presents twelve sum-of-products values.

The configuration is static during operation. It is captured from a configuration word on a load strobe and held in a register. The path from product terms to sums is purely combinational. A configuration that points an enabled cluster outside its legal window raises an error flag, and that cluster is then dropped from every sum.

Top module: `pt_steer_alloc`

## Requirements
- R1: While reset is asserted and after it is released, the held configuration is all zero: every cluster is unused, every sum reads 0 whatever the product terms are, and cfgError reads 0.
- R2: The configuration register takes cfgWord on a rising clock edge where cfgLoad is 1, and the new routing is visible right after that edge. Changing cfgWord while cfgLoad is 0 has no effect on sums or cfgError.
- R3: Cluster c (0 to 11) is controlled by cfgWord bits [3c+2:3c]: bit 3c+2 is the enable and bits [3c+1:3c] are the offset. The target macrocell is c - 2 + offset.
- R4: Macrocell i (1 to 10) can be reached only from clusters i-1, i, i+1 and i+2, clipped to 0..11. Macrocell 0 is reachable only from clusters 0, 1 and 2. Macrocell 11 is reachable only from clusters 10 and 11.
- R5: Each sum is the OR of all four product terms of every cluster steered to that macrocell. Term t of cluster c is pterms[4c+t]. A change on pterms reaches sums in the same cycle, with no register on the way.
- R6: A macrocell that has no cluster steered to it outputs 0.
- R7: A cluster whose enable bit is 0 contributes to no sum. Its offset is ignored and does not raise cfgError.
- R8: An enabled cluster whose target lies below 0 or above 11 drives cfgError to 1 and contributes to no sum. cfgError is 0 when no enabled cluster is out of range.
- R9: A cluster feeds at most one macrocell. Up to four clusters, which is 16 product terms, can be combined on one macrocell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low asynchronous reset that clears the configuration |
| cfgLoad | input | 1 | Load strobe for the configuration register |
| cfgWord | input | 36 | Configuration word: three bits per cluster |
| pterms | input | 48 | Product-term results, four per cluster |
| sums | output | 12 | Sum-of-products value for each macrocell |
| cfgError | output | 1 | High when an enabled cluster is steered outside its window |

## Verification
The hardest cases to reach from the ports are the clipped window edges. Clusters 0, 1 and 11 each have offsets that point off the end of the macrocell range, and random configurations rarely hit them one at a time with the rest of the word kept clean. The bench therefore loads directed words: each such edge offset alone with its cluster enabled, the same offset with the cluster disabled, and four clusters stacked on one macrocell. Random configurations and random terms then run against a behavioural model that is compared on every clock, and cfgWord is also changed with the strobe held low.

// File: rtl/pt_steer_pkg.sv
package pt_steer_pkg;
  // geometry of one logic block
  localparam int CLUSTERS  = 12;
  localparam int TERMS_PER = 4;
  localparam int MACROS    = 12;
  localparam int OFF_W     = 2;
  // window of cluster c spans macrocells c-BELOW .. c-BELOW+2**OFF_W-1
  localparam int BELOW     = 2;

  localparam int FLD_W = OFF_W + 1;
  localparam int CFG_W = CLUSTERS * FLD_W;
  localparam int PT_W  = CLUSTERS * TERMS_PER;

  typedef struct packed {
    logic             en;
    logic [OFF_W-1:0] off;
  } clFld_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [CLUSTERS-1:0][MACROS-1:0] route;
    logic [CLUSTERS-1:0]             badCl;
  } steer_t;
endpackage

// File: rtl/pt_steer_ctrl.sv
module pt_steer_ctrl
  import pt_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgLoad,
  input  logic [CFG_W-1:0] cfgWord,
  output logic [CFG_W-1:0] cfgQ,
  output steer_t           steer,
  output logic             cfgError
);
  // held configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfgQ <= '0;
    else if (cfgLoad) cfgQ <= cfgWord;
  end

  // per-cluster decode of target macrocell
  for (genvar c = 0; c < CLUSTERS; c++) begin : g_cl
    clFld_t fld;
    int     tgt;
    logic   inRange;

    assign fld     = clFld_t'(cfgQ[c*FLD_W +: FLD_W]);

    always_comb begin
      tgt     = c - BELOW + int'(fld.off);
      inRange = (tgt >= 0) && (tgt < MACROS);
    end

    assign steer.badCl[c] = fld.en && !inRange;

    for (genvar m = 0; m < MACROS; m++) begin : g_mc
      assign steer.route[c][m] = fld.en && inRange && (tgt == m);
    end
  end

  assign cfgError = |steer.badCl;
endmodule

// File: rtl/pt_steer_dp.sv
module pt_steer_dp
  import pt_steer_pkg::*;
(
  input  logic [PT_W-1:0]   pterms,
  input  steer_t            steer,
  output logic [MACROS-1:0] sums
);
  logic [CLUSTERS-1:0] clusterHit;

  for (genvar c = 0; c < CLUSTERS; c++) begin : g_hit
    assign clusterHit[c] = |pterms[c*TERMS_PER +: TERMS_PER];
  end

  for (genvar m = 0; m < MACROS; m++) begin : g_sum
    logic [CLUSTERS-1:0] colSel;
    for (genvar c = 0; c < CLUSTERS; c++) begin : g_col
      assign colSel[c] = steer.route[c][m];
    end
    assign sums[m] = |(colSel & clusterHit);
  end
endmodule

// File: rtl/pt_steer_alloc.sv
module pt_steer_alloc
  import pt_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgLoad,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [PT_W-1:0]   pterms,
  output logic [MACROS-1:0] sums,
  output logic              cfgError
);
  logic [CFG_W-1:0] cfgQ;
  steer_t           steer;

  pt_steer_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgLoad  (cfgLoad),
    .cfgWord  (cfgWord),
    .cfgQ     (cfgQ),
    .steer    (steer),
    .cfgError (cfgError)
  );

  pt_steer_dp u_dp (
    .pterms (pterms),
    .steer  (steer),
    .sums   (sums)
  );
endmodule

// File: rtl/pt_steer_chk.sv
module pt_steer_chk
  import pt_steer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfgLoad,
  input logic [CFG_W-1:0]  cfgWord,
  input logic [PT_W-1:0]   pterms,
  input logic [MACROS-1:0] sums,
  input logic              cfgError,
  input logic [CFG_W-1:0]  cfgQ,
  input steer_t            steer
);
  // R2: strobe captures the word
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfgLoad |=> cfgQ == $past(cfgWord));

  // R2: without the strobe the configuration holds
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgLoad |=> $stable(cfgQ));

  // R5: no asserted term means no asserted sum
  p_no_terms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pterms == '0) |-> (sums == '0));

  // R4: macrocell 0 only sees clusters 0..2
  p_window_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pterms[3*TERMS_PER-1:0] == '0) |-> !sums[0]);

  // R4: last macrocell only sees the last two clusters
  p_window_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pterms[PT_W-1 -: 2*TERMS_PER] == '0) |-> !sums[MACROS-1]);

  // R8: error flag follows out-of-range clusters
  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgError |-> (steer.badCl == '0));

  for (genvar c = 0; c < CLUSTERS; c++) begin : g_chk
    // R9: a cluster never feeds two macrocells
    p_single_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(steer.route[c]));
    // R8: an out-of-range cluster feeds nobody
    p_bad_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      steer.badCl[c] |-> (steer.route[c] == '0));
  end
endmodule

bind pt_steer_alloc pt_steer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfgLoad  (cfgLoad),
  .cfgWord  (cfgWord),
  .pterms   (pterms),
  .sums     (sums),
  .cfgError (cfgError),
  .cfgQ     (cfgQ),
  .steer    (steer)
);

// File: tb/sim_pt_steer_alloc.sv
`timescale 1ns/1ps
module sim_pt_steer_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [35:0] cfgWord = '0;
  logic [47:0] pterms = '0;
  logic [11:0] sums;
  logic        cfgError;

  int    compared = 0;
  int    mismatched = 0;
  bit    finished = 1'b0;
  string curTag = "R1";
  logic [35:0] modelCfg = '0;

  always #10 clk = ~clk;  // 50 MHz

  pt_steer_alloc u0 (
    .clk(clk), .rst_n(rst_n), .cfgLoad(cfgLoad), .cfgWord(cfgWord),
    .pterms(pterms), .sums(sums), .cfgError(cfgError)
  );

  // behavioural model of the held configuration
  always @(posedge clk) begin
    if (!rst_n)       modelCfg <= '0;
    else if (cfgLoad) modelCfg <= cfgWord;
  end

  function automatic logic [11:0] expSums(logic [35:0] cfg, logic [47:0] pt);
    logic [11:0] s = '0;
    for (int c = 0; c < 12; c++) begin
      int en  = cfg[3*c+2];
      int off = cfg[3*c +: 2];
      int tgt = c - 2 + off;
      if (en == 1 && tgt >= 0 && tgt <= 11)
        for (int t = 0; t < 4; t++)
          if (pt[4*c+t]) s[tgt] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic expErr(logic [35:0] cfg);
    logic e = 1'b0;
    for (int c = 0; c < 12; c++) begin
      int tgt = c - 2 + int'(cfg[3*c +: 2]);
      if (cfg[3*c+2] && (tgt < 0 || tgt > 11)) e = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [35:0] fld(logic [35:0] w, int c, bit en, int off);
    logic [35:0] r = w;
    r[3*c+2]   = en;
    r[3*c +: 2] = off[1:0];
    return r;
  endfunction

  // advance one clock and compare away from the edge
  task automatic tick();
    logic [11:0] es;
    logic        ee;
    @(posedge clk);
    @(negedge clk);
    es = expSums(modelCfg, pterms);
    ee = expErr(modelCfg);
    compared++;
    if (sums !== es || cfgError !== ee) begin
      mismatched++;
      $display("FAIL %s sums act=%h exp=%h cfgError act=%b exp=%b",
               curTag, sums, es, cfgError, ee);
    end
  endtask

  task automatic loadCfg(logic [35:0] w);
    cfgWord = w;
    cfgLoad = 1'b1;
    tick();
    cfgLoad = 1'b0;
  endtask

  initial begin
    logic [35:0] w;
    // R1: reset clears routing even with all terms high
    pterms = '1;
    cfgWord = '1;
    curTag = "R1";
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    tick();

    // R3 / R5: each cluster to its own index (offset 2)
    curTag = "R3";
    w = '0;
    for (int c = 0; c < 12; c++) w = fld(w, c, 1'b1, 2);
    loadCfg(w);
    for (int t = 0; t < 48; t++) begin
      curTag = "R5";
      pterms = 48'h1 << t;
      tick();
    end

    // R2: word changes without strobe have no effect
    curTag = "R2";
    pterms = 48'hA5A5_5A5A_F00F;
    cfgWord = '0;
    tick();
    cfgWord = 36'hFFF_FFF_FFF;
    tick();

    // R9: four clusters stacked on macrocell 5, others idle
    curTag = "R9";
    w = '0;
    w = fld(w, 4, 1'b1, 3);
    w = fld(w, 5, 1'b1, 2);
    w = fld(w, 6, 1'b1, 1);
    w = fld(w, 7, 1'b1, 0);
    loadCfg(w);
    for (int t = 16; t < 32; t++) begin
      pterms = 48'h1 << t;
      tick();
    end
    curTag = "R6";
    pterms = '1;
    tick();

    // R4: macrocell 0 from clusters 0,1,2 and macrocell 11 from 10,11
    curTag = "R4";
    w = '0;
    w = fld(w, 0, 1'b1, 2);
    w = fld(w, 1, 1'b1, 1);
    w = fld(w, 2, 1'b1, 0);
    w = fld(w, 10, 1'b1, 3);
    w = fld(w, 11, 1'b1, 2);
    loadCfg(w);
    for (int c = 0; c < 12; c++) begin
      pterms = 48'hF << (4*c);
      tick();
    end

    // R8: each off-range edge offset alone
    curTag = "R8";
    loadCfg(fld('0, 0, 1'b1, 0));
    loadCfg(fld('0, 0, 1'b1, 1));
    loadCfg(fld('0, 1, 1'b1, 0));
    loadCfg(fld('0, 11, 1'b1, 3));
    w = fld('0, 11, 1'b1, 3);
    w = fld(w, 10, 1'b1, 3);
    loadCfg(w);
    tick();

    // R7: the same offsets with the enable cleared
    curTag = "R7";
    w = fld('0, 0, 1'b0, 0);
    w = fld(w, 1, 1'b0, 0);
    w = fld(w, 11, 1'b0, 3);
    w = fld(w, 6, 1'b1, 3);
    loadCfg(w);
    tick();

    // random configurations and terms
    curTag = "R5";
    for (int k = 0; k < 300; k++) begin
      cfgLoad = ($urandom_range(0, 3) == 0);
      cfgWord = {$urandom, $urandom};
      pterms  = {$urandom, $urandom} & {$urandom, $urandom};
      tick();
    end
    cfgLoad = 1'b0;

    // R1: reset in the middle of operation
    curTag = "R1";
    rst_n = 1'b0;
    pterms = '1;
    tick();
    rst_n = 1'b1;
    tick();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule